// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four active-low modem handshake inputs: clear-to-send, data-set-ready, ring indicator and carrier detect. It brings each into the clock domain and shows their present asserted levels in a status byte. It also keeps a latched change flag per line that stays set until software reads the byte. Any set change flag raises an interrupt request. A modem-control byte drives four active-low outputs: terminal-ready, request-to-send and two user outputs. One bit of that byte turns on an internal loopback. In loopback the control bits stand in for the external inputs, and the external outputs fall back to their inactive level.

Each input line is tracked by a two-state machine with the states `LINE_IDLE` (line not asserted) and `LINE_ACTIVE` (line asserted). The transition `LINE_IDLE -> LINE_ACTIVE` is the leading edge. The transition `LINE_ACTIVE -> LINE_IDLE` is the trailing edge. Staying in a state is the hold transition. The clear-to-send, data-set-ready and carrier-detect machines raise a change pulse on both edges. The ring machine raises one only on the trailing edge.

Top module: `modem_status_detector`

## Requirements
- R1: After reset, the low nibble of `stat_q` is 0, `ctl_q` is 0x00, `irq_o` is 0, and all four output pins are high.
- R2: `stat_q[4]`, `stat_q[5]`, `stat_q[6]` and `stat_q[7]` hold the inverse of clear-to-send, data-set-ready, ring and carrier-detect pins respectively. A pin change shows up after the second rising clock edge that follows it.
- R3: `stat_q[0]`, `stat_q[1]` and `stat_q[3]` set on any change of clear-to-send, data-set-ready and carrier-detect respectively. Each sets one edge after the matching level bit changes.
- R4: `stat_q[2]` sets only when the ring pin goes from low to high (trailing edge of the asserted ring). A high-to-low ring pin change leaves it clear.
- R5: A set change flag stays set until a cycle with `stat_rd` high. The flag is clear from the edge that ends that cycle.
- R6: A change detected in the same cycle as `stat_rd` leaves its flag set after the read.
- R7: `ctl_q` bits 0, 1, 2 and 3 drive `dtr_n_o`, `rts_n_o`, `out1_n_o` and `out2_n_o` low when 1 and high when 0, outside loopback.
- R8: A write through `ctl_wr` stores `ctl_wdata[4:0]`. `ctl_q[7:5]` always reads 0.
- R9: With `ctl_q[4]` = 1 (loopback), the status lines follow the control bits, not the pins. Request-to-send feeds clear-to-send, terminal-ready feeds data-set-ready, user output 1 feeds ring and user output 2 feeds carrier detect. Level bits follow on the same cycle as the control byte, and change flags one edge later.
- R10: In loopback all four output pins are high whatever the control bits hold.
- R11: `irq_o` is high exactly when any of `stat_q[3:0]` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cts_n_i | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n_i | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n_i | input | 1 | Ring indicator pin, active low, asynchronous |
| dcd_n_i | input | 1 | Carrier detect pin, active low, asynchronous |
| ctl_wr | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_q | output | 8 | Control byte read-back |
| stat_rd | input | 1 | Status read strobe; clears change flags |
| stat_q | output | 8 | Status byte: levels in 7:4, change flags in 3:0 |
| dtr_n_o | output | 1 | Terminal-ready output, active low |
| rts_n_o | output | 1 | Request-to-send output, active low |
| out1_n_o | output | 1 | User output 1, active low |
| out2_n_o | output | 1 | User output 2, active low |
| irq_o | output | 1 | Change interrupt request |

## Verification
The bench builds the block with its default of two synchronizer stages. That fixes the pin-to-level delay at two edges and the pin-to-flag delay at three. It can then land a status read on exactly the cycle in which a change is detected, and check that read-versus-set race. Single-cycle control writes reach the loopback path with no synchronizer in the way. Both the same-cycle level update and the one-edge flag delay can be checked directly.

// File: rtl/msd_pkg.sv
package msd_pkg;
    localparam int NUM_LINES = 4;
    localparam int CTL_W     = 8;
    localparam int CTL_USED  = 5;

    // line index: also the change-flag bit, and level bit = index + NUM_LINES
    localparam int LN_CTS = 0;
    localparam int LN_DSR = 1;
    localparam int LN_RI  = 2;
    localparam int LN_DCD = 3;

    // control byte bit positions
    localparam int CB_DTR  = 0;
    localparam int CB_RTS  = 1;
    localparam int CB_OUT1 = 2;
    localparam int CB_OUT2 = 3;
    localparam int CB_LOOP = 4;

    typedef enum logic {
        LINE_IDLE   = 1'b0,
        LINE_ACTIVE = 1'b1
    } line_st_e;
endpackage

// File: rtl/msd_sync.sv
module msd_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/msd_line_fsm.sv
module msd_line_fsm
    import msd_pkg::*;
#(
    parameter bit TRAILING_ONLY = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,   // asserted (active-high) level of the line
    output logic set_o      // one-cycle change pulse
);
    line_st_e st, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= LINE_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt   = st;
        set_o = 1'b0;
        unique case (st)
            LINE_IDLE: begin
                if (level_i) begin
                    nxt   = LINE_ACTIVE;
                    set_o = !TRAILING_ONLY;
                end
            end
            LINE_ACTIVE: begin
                if (!level_i) begin
                    nxt   = LINE_IDLE;
                    set_o = 1'b1;
                end
            end
        endcase
    end

    // a change pulse always coincides with the tracked state moving
    assert_pulse_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_o |=> (st != $past(st)));
endmodule

// File: rtl/modem_status_detector.sv
module modem_status_detector
    import msd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cts_n_i,
    input  logic             dsr_n_i,
    input  logic             ri_n_i,
    input  logic             dcd_n_i,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_q,
    input  logic             stat_rd,
    output logic [7:0]       stat_q,
    output logic             dtr_n_o,
    output logic             rts_n_o,
    output logic             out1_n_o,
    output logic             out2_n_o,
    output logic             irq_o
);
    logic [CTL_USED-1:0]  ctl;
    logic [NUM_LINES-1:0] pin_n, sync_n, loop_src, lvl, chg, dlt;
    logic                 loop_en;

    // control byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl <= '0;
        else if (ctl_wr) ctl <= ctl_wdata[CTL_USED-1:0];
    end

    assign ctl_q   = {{(CTL_W-CTL_USED){1'b0}}, ctl};
    assign loop_en = ctl[CB_LOOP];

    assign dtr_n_o  = loop_en | ~ctl[CB_DTR];
    assign rts_n_o  = loop_en | ~ctl[CB_RTS];
    assign out1_n_o = loop_en | ~ctl[CB_OUT1];
    assign out2_n_o = loop_en | ~ctl[CB_OUT2];

    // input lines, indexed by line number
    assign pin_n[LN_CTS] = cts_n_i;
    assign pin_n[LN_DSR] = dsr_n_i;
    assign pin_n[LN_RI]  = ri_n_i;
    assign pin_n[LN_DCD] = dcd_n_i;

    assign loop_src[LN_CTS] = ctl[CB_RTS];
    assign loop_src[LN_DSR] = ctl[CB_DTR];
    assign loop_src[LN_RI]  = ctl[CB_OUT1];
    assign loop_src[LN_DCD] = ctl[CB_OUT2];

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        msd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d_i  (pin_n[i]),
            .q_o  (sync_n[i])
        );

        assign lvl[i] = loop_en ? loop_src[i] : ~sync_n[i];

        msd_line_fsm #(.TRAILING_ONLY(i == LN_RI)) u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .level_i(lvl[i]),
            .set_o  (chg[i])
        );

        // sticky flag: a new change wins over a read in the same cycle
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dlt[i] <= 1'b0;
            else        dlt[i] <= chg[i] | (dlt[i] & ~stat_rd);
        end
    end

    assign stat_q = {lvl, dlt};
    assign irq_o  = |dlt;

    // ---------------- assertions ----------------
    assert_ctl_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> ctl_q == ($past(ctl_wdata) & 8'h1F));

    assert_loop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[CB_LOOP] |-> ({dtr_n_o, rts_n_o, out1_n_o, out2_n_o} == 4'hF));

    assert_clear_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && chg == '0) |=> stat_q[3:0] == 4'h0);

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> (stat_q[3:0] & $past(stat_q[3:0])) == $past(stat_q[3:0]));

    assert_read_race_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && chg != '0) |=> (stat_q[3:0] & $past(chg)) == $past(chg));

    assert_ring_leading_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_q[LN_RI] && stat_q[NUM_LINES+LN_RI]) |=> !stat_q[LN_RI]);

    assert_irq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !stat_rd) |=> irq_o);

    assert_irq_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && chg == '0) |=> !irq_o);
endmodule

// File: tb/modem_status_detector_tb.sv
`timescale 1ns/1ps
module modem_status_detector_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_n_i = 1'b1, dsr_n_i = 1'b1, ri_n_i = 1'b1, dcd_n_i = 1'b1;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] ctl_q;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_q;
    logic       dtr_n_o, rts_n_o, out1_n_o, out2_n_o, irq_o;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    modem_status_detector u_dut (
        .clk(clk), .rst_n(rst_n),
        .cts_n_i(cts_n_i), .dsr_n_i(dsr_n_i), .ri_n_i(ri_n_i), .dcd_n_i(dcd_n_i),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
        .stat_rd(stat_rd), .stat_q(stat_q),
        .dtr_n_o(dtr_n_o), .rts_n_o(rts_n_o), .out1_n_o(out1_n_o), .out2_n_o(out2_n_o),
        .irq_o(irq_o)
    );

    // {pins (bit i: 0 cts,1 dsr,2 ri,3 dcd), expected stat_q three edges later}
    localparam logic [11:0] VEC [9] = '{
        {4'hE, 8'h11}, {4'hC, 8'h32}, {4'h8, 8'h70}, {4'hC, 8'h34}, {4'h4, 8'hB8},
        {4'hF, 8'h0B}, {4'hF, 8'h00}, {4'h0, 8'hFB}, {4'hF, 8'h0F}
    };

    function automatic logic [7:0] pins_out();
        return {4'h0, out2_n_o, out1_n_o, rts_n_o, dtr_n_o};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_pins(input logic [3:0] p);
        {dcd_n_i, ri_n_i, dsr_n_i, cts_n_i} = p;
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic rd_stat();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 stat", stat_q, 8'h00);
        chk("R1 ctl", ctl_q, 8'h00);
        chk("R1 irq", {7'd0, irq_o}, 8'h00);
        chk("R1 pins", pins_out(), 8'h0F);

        // table walk: R2 levels, R3 any-change flags, R4 ring trailing only, R5, R11
        for (int k = 0; k < 9; k++) begin
            @(negedge clk); set_pins(VEC[k][11:8]);
            repeat (3) @(negedge clk);
            chk($sformatf("R2/R3/R4 vec%0d", k), stat_q, VEC[k][7:0]);
            chk($sformatf("R11 vec%0d", k), {7'd0, irq_o}, {7'd0, |VEC[k][3:0]});
            repeat (2) @(negedge clk);
            chk($sformatf("R5 sticky vec%0d", k), stat_q, VEC[k][7:0]);
            rd_stat();
            chk($sformatf("R5 cleared vec%0d", k), stat_q, {VEC[k][7:4], 4'h0});
            chk($sformatf("R11 low vec%0d", k), {7'd0, irq_o}, 8'h00);
        end

        // R2 timing: level not yet visible after a single edge
        @(negedge clk); set_pins(4'hE);
        @(negedge clk);
        chk("R2 one edge", stat_q, 8'h00);
        @(negedge clk);
        chk("R2 two edges", stat_q, 8'h10);
        @(negedge clk); rd_stat();
        @(negedge clk); set_pins(4'hF);
        repeat (3) @(negedge clk); rd_stat();
        chk("R3 restore", stat_q, 8'h00);

        // R6 read in the cycle the change is detected
        @(negedge clk); set_pins(4'hE);
        @(negedge clk);
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
        chk("R6 race keeps flag", stat_q, 8'h11);
        rd_stat();
        chk("R6 later read clears", stat_q, 8'h10);
        @(negedge clk); set_pins(4'hF);
        repeat (3) @(negedge clk); rd_stat();

        // R7 output polarity, R8 reserved bits
        wr_ctl(8'h05);
        chk("R7 pins 05", pins_out(), 8'h0A);
        wr_ctl(8'h0A);
        chk("R7 pins 0A", pins_out(), 8'h05);
        wr_ctl(8'hE3);
        chk("R8 readback", ctl_q, 8'h03);
        chk("R7 pins 03", pins_out(), 8'h0C);

        // R9 loopback routing, R10 outputs inactive
        wr_ctl(8'h10);
        chk("R8 loop bit", ctl_q, 8'h10);
        chk("R10 pins loop idle", pins_out(), 8'h0F);
        chk("R9 loop idle", stat_q, 8'h00);
        wr_ctl(8'h12);
        chk("R9 rts->cts level", stat_q, 8'h10);
        @(negedge clk);
        chk("R9 rts->cts flag", stat_q, 8'h11);
        chk("R10 pins loop rts", pins_out(), 8'h0F);
        rd_stat();
        wr_ctl(8'h1F);
        @(negedge clk);
        chk("R9 all on", stat_q, 8'hFA);
        chk("R10 pins loop all", pins_out(), 8'h0F);
        rd_stat();
        @(negedge clk); set_pins(4'h0);
        repeat (4) @(negedge clk);
        chk("R9 pins ignored", stat_q, 8'hF0);
        wr_ctl(8'h10);
        @(negedge clk);
        chk("R9 all off", stat_q, 8'h0F);
        chk("R11 loop irq", {7'd0, irq_o}, 8'h01);
        rd_stat();
        chk("R9 cleared", stat_q, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule